// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block holds the configuration and status registers of an SDRAM controller. Software reaches them through two register numbers on a simple device-control bus. The first number is an index port, which latches a 32-bit register offset. The second number is a data window, which reads or writes the register that the latched offset selects. Each register applies its own rule to incoming data. Some keep only certain bits. Some clear the bits written as one. Some force fixed bits. Some return a fixed value on read.

The block drives the controller-enable bit, the bank-configuration words and the timing word to the rest of the controller. It raises an error interrupt while the stored ECC error status holds any set bit. The enable and bank values are copies of the register contents. The block issues no SDRAM commands, generates no refresh and computes no ECC.

The bus has no back-pressure. A read strobe sees its data combinationally in the same cycle. A write strobe is always accepted and updates the register at the next rising clock edge. This bus is a control path, so it carries no valid/ready handshake.

Top module: `memcfg_regfile`

## Requirements
- R1: Writing register number 0x10 (index port) stores the full 32-bit data as the offset. Reading 0x10 returns the stored offset.
- R2: At offsets 0x00 and 0x08 (bus-error status 0/1), a data write clears the bits that are 1 in the written value and never sets a bit. Offset 0x10 (error address) stores the written value unchanged.
- R3: Offset 0x20 (config) stores the written value AND 0xFFE00000. Output `ctl_enable` equals config bit 31.
- R4: Status bit 31 is cleared when a config write changes bit 31 from 0 to 1. It is set when a config write changes bit 31 from 1 to 0.
- R5: Status bit 30 is set when config bit 30 changes from 0 to 1 and cleared when it changes from 1 to 0. Writes to offset 0x24 (status) are ignored, and status changes only on config writes.
- R6: Offset 0x30 (refresh) stores the value AND 0x3FF80000. Offset 0x34 (power management) stores (value AND 0xF8000000) OR 0x07C00000.
- R7: Offset 0x80 (timing) stores the value AND 0x018FC01F, drives it on `timing_cfg`, and always reads as 0xFFFFFFFF. Offset 0x94 (ECC config) stores the value AND 0x00F00000.
- R8: Offset 0x98 (ECC error status) stores the value AND 0xFFF0F000. `err_irq` is high exactly while the stored value is nonzero, starting from the edge that writes it.
- R9: Offsets 0x40 + 4*i (bank i, i = 0..3) store the value AND 0xFFDEE001. Bank i is driven on `bank_cfg[32*i +: 32]`.
- R10: A data-window read at any other offset returns 0xFFFFFFFF, and a data-window write there changes no register.
- R11: Register numbers other than 0x10 and 0x11 read as 0 and ignore writes. `rd_data` is 0 while `rd_en` is low.
- R12: After reset, power management reads 0x07C00000, refresh reads 0x05F00000, timing holds 0x00854009, config reads 0x00800000, and the index and all other registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_num | input | 10 | Device-control register number |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the strobe cycle |
| ctl_enable | output | 1 | Controller enable (config bit 31) |
| bank_cfg | output | 128 | Bank-configuration words, bank i at bits 32*i+31:32*i |
| timing_cfg | output | 32 | Stored timing word |
| err_irq | output | 1 | ECC error interrupt |

## Verification
Reads are combinational, so the bench samples `rd_data` one nanosecond after it raises the strobe on a falling edge, in the same cycle. A write is applied at the rising edge after the strobe is raised. `ctl_enable`, `bank_cfg`, `err_irq` and the status bits therefore change at that edge. The bench compares them on the following falling edge, against a register model it updates for each write. The checker's properties use a one-cycle `|=>` for every register update, which matches this single edge of latency.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int DW = 32;

  // offsets within the data window
  localparam logic [DW-1:0] OFF_BESR0 = 32'h00;
  localparam logic [DW-1:0] OFF_BESR1 = 32'h08;
  localparam logic [DW-1:0] OFF_BEAR  = 32'h10;
  localparam logic [DW-1:0] OFF_CFG   = 32'h20;
  localparam logic [DW-1:0] OFF_STAT  = 32'h24;
  localparam logic [DW-1:0] OFF_RTR   = 32'h30;
  localparam logic [DW-1:0] OFF_PMIT  = 32'h34;
  localparam logic [DW-1:0] OFF_BANK0 = 32'h40;
  localparam logic [DW-1:0] OFF_TMG   = 32'h80;
  localparam logic [DW-1:0] OFF_ECFG  = 32'h94;
  localparam logic [DW-1:0] OFF_EESR  = 32'h98;

  // write masks
  localparam logic [DW-1:0] MSK_CFG  = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_RTR  = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_PMIT = 32'hF800_0000;
  localparam logic [DW-1:0] FIX_PMIT = 32'h07C0_0000;
  localparam logic [DW-1:0] MSK_TMG  = 32'h018F_C01F;
  localparam logic [DW-1:0] MSK_ECFG = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_EESR = 32'hFFF0_F000;
  localparam logic [DW-1:0] MSK_BANK = 32'hFFDE_E001;

  // reset values
  localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RTR  = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PMIT = 32'h07C0_0000;
  localparam logic [DW-1:0] RST_TMG  = 32'h0085_4009;

  typedef struct packed {
    logic besr0;
    logic besr1;
    logic bear;
    logic cfg;
    logic stat;
    logic rtr;
    logic pmit;
    logic tmg;
    logic ecfg;
    logic eesr;
  } memcfg_sel_t;
endpackage

// File: rtl/memcfg_decode.sv
module memcfg_decode
  import memcfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [DW-1:0]        idx,
  output memcfg_sel_t          sel,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 hit
);
  always_comb begin
    sel       = '0;
    sel.besr0 = (idx == OFF_BESR0);
    sel.besr1 = (idx == OFF_BESR1);
    sel.bear  = (idx == OFF_BEAR);
    sel.cfg   = (idx == OFF_CFG);
    sel.stat  = (idx == OFF_STAT);
    sel.rtr   = (idx == OFF_RTR);
    sel.pmit  = (idx == OFF_PMIT);
    sel.tmg   = (idx == OFF_TMG);
    sel.ecfg  = (idx == OFF_ECFG);
    sel.eesr  = (idx == OFF_EESR);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bsel
    localparam logic [DW-1:0] BOFF = OFF_BANK0 + DW'(4 * b);
    assign bank_sel[b] = (idx == BOFF);
  end

  assign hit = (|sel) | (|bank_sel);
endmodule

// File: rtl/memcfg_bank.sv
module memcfg_bank
  import memcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MSK_BANK;
  end
endmodule

// File: rtl/memcfg_cfgstat.sv
module memcfg_cfgstat
  import memcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] stat_q
);
  logic [DW-1:0] cfg_nx;
  logic [DW-1:0] stat_nx;

  always_comb begin
    cfg_nx  = wdata & MSK_CFG;
    stat_nx = stat_q;
    // enable edge: rise clears busy-style flag, fall sets it
    if (!cfg_q[31] && cfg_nx[31])      stat_nx[31] = 1'b0;
    else if (cfg_q[31] && !cfg_nx[31]) stat_nx[31] = 1'b1;
    // bit 30 follows edges of config bit 30
    if (!cfg_q[30] && cfg_nx[30])      stat_nx[30] = 1'b1;
    else if (cfg_q[30] && !cfg_nx[30]) stat_nx[30] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_CFG;
      stat_q <= '0;
    end else if (we) begin
      cfg_q  <= cfg_nx;
      stat_q <= stat_nx;
    end
  end
endmodule

// File: rtl/memcfg_regfile.sv
module memcfg_regfile
  import memcfg_pkg::*;
#(
  parameter int           ADDR_W    = 10,
  parameter logic [9:0]   IDX_PORT  = 10'h010,
  parameter logic [9:0]   DATA_PORT = 10'h011,
  parameter int           NUM_BANKS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_num,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  output logic                    ctl_enable,
  output logic [NUM_BANKS*DW-1:0] bank_cfg,
  output logic [DW-1:0]           timing_cfg,
  output logic                    err_irq
);
  localparam logic [ADDR_W-1:0] P_IDX  = ADDR_W'(IDX_PORT);
  localparam logic [ADDR_W-1:0] P_DATA = ADDR_W'(DATA_PORT);

  logic [DW-1:0] idx_q;
  logic [DW-1:0] besr0_q, besr1_q, bear_q, rtr_q, pmit_q, tmg_q, ecfg_q, eesr_q;
  logic [DW-1:0] cfg_q, stat_q;
  logic [DW-1:0] bank_q [NUM_BANKS];

  memcfg_sel_t          sel;
  logic [NUM_BANKS-1:0] bank_sel;
  logic                 hit;
  logic                 idx_wr, dat_wr;

  assign idx_wr = wr_en && (reg_num == P_IDX);
  assign dat_wr = wr_en && (reg_num == P_DATA);

  memcfg_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .idx      (idx_q),
    .sel      (sel),
    .bank_sel (bank_sel),
    .hit      (hit)
  );

  memcfg_cfgstat u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (dat_wr && sel.cfg),
    .wdata  (wr_data),
    .cfg_q  (cfg_q),
    .stat_q (stat_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    memcfg_bank u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dat_wr && bank_sel[b]),
      .wdata (wr_data),
      .q     (bank_q[b])
    );
    assign bank_cfg[b*DW +: DW] = bank_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      besr0_q <= '0;
      besr1_q <= '0;
      bear_q  <= '0;
      rtr_q   <= RST_RTR;
      pmit_q  <= RST_PMIT;
      tmg_q   <= RST_TMG;
      ecfg_q  <= '0;
      eesr_q  <= '0;
    end else begin
      if (idx_wr) idx_q <= wr_data;
      if (dat_wr) begin
        if (sel.besr0) besr0_q <= besr0_q & ~wr_data;
        if (sel.besr1) besr1_q <= besr1_q & ~wr_data;
        if (sel.bear)  bear_q  <= wr_data;
        if (sel.rtr)   rtr_q   <= wr_data & MSK_RTR;
        if (sel.pmit)  pmit_q  <= (wr_data & MSK_PMIT) | FIX_PMIT;
        if (sel.tmg)   tmg_q   <= wr_data & MSK_TMG;
        if (sel.ecfg)  ecfg_q  <= wr_data & MSK_ECFG;
        if (sel.eesr)  eesr_q  <= wr_data & MSK_EESR;
      end
    end
  end

  logic [DW-1:0] win_data;
  always_comb begin
    win_data = '1;
    if (hit) begin
      win_data = '0;
      if (sel.besr0) win_data = besr0_q;
      if (sel.besr1) win_data = besr1_q;
      if (sel.bear)  win_data = bear_q;
      if (sel.cfg)   win_data = cfg_q;
      if (sel.stat)  win_data = stat_q;
      if (sel.rtr)   win_data = rtr_q;
      if (sel.pmit)  win_data = pmit_q;
      if (sel.tmg)   win_data = '1;
      if (sel.ecfg)  win_data = ecfg_q;
      if (sel.eesr)  win_data = eesr_q;
      for (int b = 0; b < NUM_BANKS; b++)
        if (bank_sel[b]) win_data = bank_q[b];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (reg_num == P_IDX)       rd_data = idx_q;
      else if (reg_num == P_DATA) rd_data = win_data;
    end
  end

  assign ctl_enable = cfg_q[31];
  assign timing_cfg = tmg_q;
  assign err_irq    = |eesr_q;
endmodule

// File: rtl/memcfg_regfile_chk.sv
module memcfg_regfile_chk
  import memcfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [9:0]              reg_num,
  input logic                    wr_en,
  input logic [DW-1:0]           wr_data,
  input logic [DW-1:0]           idx_q,
  input logic [DW-1:0]           stat_q,
  input logic                    ctl_enable,
  input logic [NUM_BANKS*DW-1:0] bank_cfg,
  input logic                    err_irq
);
  logic dwr;
  assign dwr = wr_en && (reg_num == 10'h011);

  // R8
  eesr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == OFF_EESR) |=> (err_irq == |($past(wr_data) & MSK_EESR)));

  // R4
  enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == OFF_CFG && !ctl_enable && wr_data[31]) |=> (ctl_enable && !stat_q[31]));

  // R5
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dwr && idx_q == OFF_CFG) |=> $stable(stat_q));

  // R9
  bank0_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q == OFF_BANK0) |=> (bank_cfg[DW-1:0] == ($past(wr_data) & MSK_BANK)));

  // R11
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_num == 10'h010) |=> $stable(idx_q));
endmodule

bind memcfg_regfile memcfg_regfile_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_num    (reg_num),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .idx_q      (idx_q),
  .stat_q     (stat_q),
  .ctl_enable (ctl_enable),
  .bank_cfg   (bank_cfg),
  .err_irq    (err_irq)
);

// File: tb/sim_memcfg_regfile.sv
`timescale 1ns/1ps
module sim_memcfg_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_num = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ctl_enable;
  logic [127:0] bank_cfg;
  logic [31:0] timing_cfg;
  logic        err_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  memcfg_regfile u0 (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ctl_enable(ctl_enable),
    .bank_cfg(bank_cfg), .timing_cfg(timing_cfg), .err_irq(err_irq)
  );

  // bench register model
  logic [31:0] m_idx, m_b0, m_b1, m_bear, m_cfg, m_st, m_rtr, m_pm, m_tr, m_ecfg, m_eesr;
  logic [31:0] m_bank [4];

  task automatic model_reset();
    m_idx = 0; m_b0 = 0; m_b1 = 0; m_bear = 0; m_cfg = 32'h0080_0000; m_st = 0;
    m_rtr = 32'h05F0_0000; m_pm = 32'h07C0_0000; m_tr = 32'h0085_4009;
    m_ecfg = 0; m_eesr = 0;
    for (int i = 0; i < 4; i++) m_bank[i] = 0;
  endtask

  function automatic logic [31:0] exp_win(input logic [31:0] off);
    case (off)
      32'h00: return m_b0;
      32'h08: return m_b1;
      32'h10: return m_bear;
      32'h20: return m_cfg;
      32'h24: return m_st;
      32'h30: return m_rtr;
      32'h34: return m_pm;
      32'h40: return m_bank[0];
      32'h44: return m_bank[1];
      32'h48: return m_bank[2];
      32'h4C: return m_bank[3];
      32'h94: return m_ecfg;
      32'h98: return m_eesr;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic model_wr(input logic [31:0] off, input logic [31:0] v);
    logic [31:0] nv;
    case (off)
      32'h00: m_b0 = m_b0 & ~v;
      32'h08: m_b1 = m_b1 & ~v;
      32'h10: m_bear = v;
      32'h20: begin
        nv = v & 32'hFFE0_0000;
        if (!m_cfg[31] && nv[31]) m_st[31] = 1'b0;
        else if (m_cfg[31] && !nv[31]) m_st[31] = 1'b1;
        if (!m_cfg[30] && nv[30]) m_st[30] = 1'b1;
        else if (m_cfg[30] && !nv[30]) m_st[30] = 1'b0;
        m_cfg = nv;
      end
      32'h30: m_rtr = v & 32'h3FF8_0000;
      32'h34: m_pm = (v & 32'hF800_0000) | 32'h07C0_0000;
      32'h40: m_bank[0] = v & 32'hFFDE_E001;
      32'h44: m_bank[1] = v & 32'hFFDE_E001;
      32'h48: m_bank[2] = v & 32'hFFDE_E001;
      32'h4C: m_bank[3] = v & 32'hFFDE_E001;
      32'h80: m_tr = v & 32'h018F_C01F;
      32'h94: m_ecfg = v & 32'h00F0_0000;
      32'h98: m_eesr = v & 32'hFFF0_F000;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] num, input logic [31:0] d);
    @(negedge clk);
    reg_num = num; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] num, output logic [31:0] d);
    @(negedge clk);
    reg_num = num; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic set_idx(input logic [31:0] off);
    bus_wr(10'h010, off);
    m_idx = off;
  endtask

  task automatic win_wr(input logic [31:0] off, input logic [31:0] v);
    set_idx(off);
    bus_wr(10'h011, v);
    model_wr(off, v);
  endtask

  task automatic win_chk(input string tag, input logic [31:0] off);
    logic [31:0] d;
    set_idx(off);
    bus_rd(10'h011, d);
    check(tag, d, exp_win(off));
  endtask

  task automatic out_chk(input string tag);
    check({tag, " R3 ctl_enable"}, {31'd0, ctl_enable}, {31'd0, m_cfg[31]});
    check({tag, " R8 err_irq"}, {31'd0, err_irq}, {31'd0, |m_eesr});
    for (int i = 0; i < 4; i++)
      check({tag, " R9 bank_cfg"}, bank_cfg[32*i +: 32], m_bank[i]);
    check({tag, " R7 timing_cfg"}, timing_cfg, m_tr);
  endtask

  function automatic logic [31:0] pick_off(input int k);
    case (k)
      0: return 32'h00;  1: return 32'h08;  2: return 32'h10;  3: return 32'h20;
      4: return 32'h24;  5: return 32'h30;  6: return 32'h34;  7: return 32'h40;
      8: return 32'h44;  9: return 32'h48; 10: return 32'h4C; 11: return 32'h80;
      12: return 32'h94; 13: return 32'h98;
      default: return 32'h100 + 32'($urandom % 256) * 4;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset values
    bus_rd(10'h010, d); check("R12 index reset", d, 32'h0);
    win_chk("R12 besr0 reset", 32'h00);
    win_chk("R12 refresh reset", 32'h30);
    win_chk("R12 pm reset", 32'h34);
    win_chk("R12 cfg reset", 32'h20);
    win_chk("R12 status reset", 32'h24);
    check("R12 timing reset", timing_cfg, 32'h0085_4009);
    out_chk("R12 reset");

    // R1 index readback
    set_idx(32'hDEAD_BEEF);
    bus_rd(10'h010, d); check("R1 index readback", d, 32'hDEAD_BEEF);

    // R4 / R5 transitions
    win_wr(32'h20, 32'hC000_0000);
    win_chk("R4 R5 status after enable", 32'h24); out_chk("R4 rise");
    win_wr(32'h20, 32'h0000_0000);
    win_chk("R4 R5 status after disable", 32'h24); out_chk("R4 fall");
    win_wr(32'h24, 32'h0000_0000);
    win_chk("R5 status write ignored", 32'h24);
    check("R5 status bit31 set", m_st, 32'h8000_0000);

    // R7 timing reads all ones
    win_wr(32'h80, 32'hFFFF_FFFF);
    win_chk("R7 timing read", 32'h80);
    check("R7 timing stored", timing_cfg, 32'h018F_C01F);

    // R8 interrupt
    win_wr(32'h98, 32'h000F_0FFF);
    out_chk("R8 masked-out write");
    win_wr(32'h98, 32'h0000_1000);
    out_chk("R8 raise");
    win_wr(32'h98, 32'h0);
    out_chk("R8 lower");

    // R10 undefined offset
    win_wr(32'h0000_0004, 32'h1234_5678);
    win_chk("R10 undefined read", 32'h0000_0004);
    out_chk("R10 undefined write");

    // R11 other register numbers, rd_en low
    set_idx(32'h20);
    bus_wr(10'h012, 32'h8000_0000);
    bus_rd(10'h012, d); check("R11 other regnum read", d, 32'h0);
    bus_rd(10'h010, d); check("R11 index unchanged", d, 32'h20);
    out_chk("R11 no effect");
    @(negedge clk); reg_num = 10'h010; #1;
    check("R11 rd_en low", rd_data, 32'h0);

    // R2 W1C and error address
    win_wr(32'h00, 32'hFFFF_FFFF); win_chk("R2 besr0 W1C", 32'h00);
    win_wr(32'h08, 32'hFFFF_FFFF); win_chk("R2 besr1 W1C", 32'h08);
    win_wr(32'h10, 32'hA5A5_5A5A); win_chk("R2 bear", 32'h10);

    // random mix: R2 R3 R6 R7 R9 R10
    for (int n = 0; n < 400; n++) begin
      logic [31:0] off;
      logic [31:0] v;
      off = pick_off(int'($urandom % 16));
      v = $urandom;
      if ($urandom % 2 == 0) begin
        win_wr(off, v);
        out_chk("R3 R9 random write");
      end else begin
        win_chk("R6 R10 random read", off);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule